// File: doc/BRIEF.md
# DDR2 Self-Refresh Entry/Exit Sequencer

This block takes a DDR2 device into self-refresh and brings it back out. It sits between the memory controller's command path and the device pins. While the controller owns the device, its command and on-die-termination signals pass straight through. When the controller asks for self-refresh, the sequencer takes over the pins and performs the entry:

1. It turns termination off and waits for a settle time and for all banks to report idle.
2. If the device has left self-refresh since its last auto-refresh, it issues the extra auto-refresh and waits out the refresh cycle time.
3. It drives the self-refresh command with the clock enable low and, one cycle later, gates the device clock.

On an exit request the sequencer performs the exit:

1. It lets a minimum residency pass, holding an early exit request until then.
2. It restarts the clock and waits for it to settle.
3. It raises the clock enable.
4. It drives only NOP commands, with termination held off, through the exit window.
5. It returns the pins to the controller and raises its ready flag.

All times are parameters counted in controller clock cycles.

Top module: `sr_sequencer`

Command pins are the 4-bit vector {cs_n, ras_n, cas_n, we_n}. The sequencer uses these codes: NOP = 4'b0111, deselect = 4'b1111, auto-refresh = 4'b0001 with the clock enable high, and self-refresh entry = 4'b0001 with the clock enable low. The parameters must satisfy T_RFC >= 2 and T_XSRD > T_XSNR.

## Requirements
- R1: After reset, sr_ready, dram_cke and dram_clk_en are 1. dram_cmd and dram_odt equal host_cmd and host_odt in the same cycle.
- R2: An enter request sampled while sr_ready is 1 starts entry. dram_odt goes to 0 and dram_cmd to NOP for at least T_ODT cycles, and further until banks_idle has been sampled 1.
- R3: Self-refresh entry is a single cycle with dram_cmd = 4'b0001, dram_cke = 0 and dram_odt = 0.
- R4: After every exit an extra auto-refresh is owed. While it is owed, entry issues one dram_cmd = 4'b0001 with dram_cke = 1 exactly T_RFC cycles before the entry command, with NOP in between. The debt is also cleared by a host_cmd of 4'b0001 passed through while sr_ready is 1; after that, entry issues no refresh.
- R5: The device stays in self-refresh at least T_CKE cycles after the entry cycle. An exit request arriving earlier, even in the entry cycle itself, is held and acted on once that time is up.
- R6: dram_clk_en is 0 from the cycle after entry until the exit is accepted. It returns to 1 exactly T_CLK cycles before dram_cke rises, and is never 0 while dram_cke is 1.
- R7: While dram_cke is 0 after the entry cycle, dram_cmd is deselect (4'b1111).
- R8: From the cycle dram_cke rises, for T_XSRD cycles, dram_cke stays 1, dram_cmd is NOP, dram_odt is 0 and sr_ready is 0. The first T_XSNR of those cycles form the NOP-only exit window. sr_ready returns to 1 in the following cycle.
- R9: An exit request outside the entry and self-refresh states has no effect and is not remembered. An enter request while sr_ready is 0 has no effect.
- R10: While sr_ready is 1, dram_cke and dram_clk_en are 1 and the host command and termination pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_enter_req | input | 1 | Request to enter self-refresh, sampled when ready |
| sr_exit_req | input | 1 | Request to leave self-refresh |
| banks_idle | input | 1 | All banks precharged and idle |
| host_cmd | input | 4 | Controller command {cs_n, ras_n, cas_n, we_n} |
| host_odt | input | 1 | Controller termination request |
| dram_cke | output | 1 | Device clock enable |
| dram_clk_en | output | 1 | Enable for the device clock gate |
| dram_odt | output | 1 | Device termination pin |
| dram_cmd | output | 4 | Device command pins {cs_n, ras_n, cas_n, we_n} |
| sr_ready | output | 1 | Controller owns the device pins |

## Verification
The hardest situation to reach is an exit request that lands while the residency timer is still running: in the very entry cycle, or at the exact last cycle of the minimum. Both the pending-exit latch and the direct path are involved there, and an off-by-one moves the clock-enable rise by one cycle. The random stimulus therefore draws the exit delay from a range that straddles T_CKE. It also draws the bank-idle delay from a range around T_ODT, alternates runs with and without an owed refresh, and injects stray exit and enter pulses in states where they must be ignored. A bench model predicts every pin in every cycle of each sequence.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ODT_OFF,
        ST_AREF,
        ST_AREF_WAIT,
        ST_ENTER,
        ST_IN_SR,
        ST_CLK_RESTART,
        ST_EXIT_NOP,
        ST_EXIT_HOLD,
        ST_READY
    } sr_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP   = 4'b0111;
    localparam logic [3:0] CMD_DESEL = 4'b1111;
    localparam logic [3:0] CMD_REF   = 4'b0001; // with CKE low it means self-refresh entry

    typedef struct packed {
        sr_state_e state;
        logic      ref_owed;
        logic      exit_pend;
    } sr_ctx_t;

endpackage

// File: rtl/sr_timer.sv
module sr_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sr_pinmux.sv
module sr_pinmux
    import sr_pkg::*;
(
    input  sr_state_e   state,
    input  logic [3:0]  host_cmd,
    input  logic        host_odt,
    output logic        cke,
    output logic        clk_en,
    output logic        odt,
    output logic [3:0]  cmd,
    output logic        ready
);
    always_comb begin
        cke    = 1'b1;
        clk_en = 1'b1;
        odt    = 1'b0;
        cmd    = CMD_NOP;
        ready  = 1'b0;
        unique case (state)
            ST_IDLE, ST_READY: begin
                odt   = host_odt;
                cmd   = host_cmd;
                ready = 1'b1;
            end
            ST_AREF: begin
                cmd = CMD_REF;
            end
            ST_ENTER: begin
                cke = 1'b0;
                cmd = CMD_REF;
            end
            ST_IN_SR: begin
                cke    = 1'b0;
                clk_en = 1'b0;
                cmd    = CMD_DESEL;
            end
            ST_CLK_RESTART: begin
                cke = 1'b0;
                cmd = CMD_DESEL;
            end
            default: begin
                cmd = CMD_NOP;
            end
        endcase
    end
endmodule

// File: rtl/sr_sequencer.sv
module sr_sequencer
    import sr_pkg::*;
#(
    parameter int T_ODT  = 3,
    parameter int T_RFC  = 6,
    parameter int T_CKE  = 4,
    parameter int T_CLK  = 3,
    parameter int T_XSNR = 8,
    parameter int T_XSRD = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sr_enter_req,
    input  logic       sr_exit_req,
    input  logic       banks_idle,
    input  logic [3:0] host_cmd,
    input  logic       host_odt,
    output logic       dram_cke,
    output logic       dram_clk_en,
    output logic       dram_odt,
    output logic [3:0] dram_cmd,
    output logic       sr_ready
);
    localparam int M1    = (T_ODT > T_RFC) ? T_ODT : T_RFC;
    localparam int M2    = (T_CKE > T_CLK) ? T_CKE : T_CLK;
    localparam int M3    = (T_XSNR > T_XSRD) ? T_XSNR : T_XSRD;
    localparam int M12   = (M1 > M2) ? M1 : M2;
    localparam int T_MAX = (M12 > M3) ? M12 : M3;
    localparam int CW    = $clog2(T_MAX + 1);

    localparam logic [CW-1:0] LD_ODT  = CW'(T_ODT - 1);
    localparam logic [CW-1:0] LD_RFC  = CW'(T_RFC - 2);
    localparam logic [CW-1:0] LD_CKE  = CW'(T_CKE - 1);
    localparam logic [CW-1:0] LD_CLK  = CW'(T_CLK - 1);
    localparam logic [CW-1:0] LD_XSNR = CW'(T_XSNR - 1);
    localparam logic [CW-1:0] LD_HOLD = CW'(T_XSRD - T_XSNR - 1);

    sr_ctx_t         ctx_d, ctx_q;
    logic            tmr_load;
    logic [CW-1:0]   tmr_val;
    logic            tmr_zero;

    sr_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_comb begin
        ctx_d    = ctx_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (ctx_q.state)
            ST_IDLE, ST_READY: begin
                if (host_cmd == CMD_REF) begin
                    ctx_d.ref_owed = 1'b0;
                    ctx_d.state    = ST_IDLE;
                end
                if (sr_enter_req) begin
                    ctx_d.state = ST_ODT_OFF;
                    tmr_load    = 1'b1;
                    tmr_val     = LD_ODT;
                end
            end
            ST_ODT_OFF: begin
                if (tmr_zero && banks_idle) begin
                    ctx_d.state = ctx_q.ref_owed ? ST_AREF : ST_ENTER;
                end
            end
            ST_AREF: begin
                ctx_d.state    = ST_AREF_WAIT;
                ctx_d.ref_owed = 1'b0;
                tmr_load       = 1'b1;
                tmr_val        = LD_RFC;
            end
            ST_AREF_WAIT: begin
                if (tmr_zero) begin
                    ctx_d.state = ST_ENTER;
                end
            end
            ST_ENTER: begin
                ctx_d.state     = ST_IN_SR;
                ctx_d.exit_pend = sr_exit_req;
                tmr_load        = 1'b1;
                tmr_val         = LD_CKE;
            end
            ST_IN_SR: begin
                if (sr_exit_req) begin
                    ctx_d.exit_pend = 1'b1;
                end
                if (tmr_zero && (sr_exit_req || ctx_q.exit_pend)) begin
                    ctx_d.state     = ST_CLK_RESTART;
                    ctx_d.exit_pend = 1'b0;
                    tmr_load        = 1'b1;
                    tmr_val         = LD_CLK;
                end
            end
            ST_CLK_RESTART: begin
                if (tmr_zero) begin
                    ctx_d.state = ST_EXIT_NOP;
                    tmr_load    = 1'b1;
                    tmr_val     = LD_XSNR;
                end
            end
            ST_EXIT_NOP: begin
                if (tmr_zero) begin
                    ctx_d.state = ST_EXIT_HOLD;
                    tmr_load    = 1'b1;
                    tmr_val     = LD_HOLD;
                end
            end
            ST_EXIT_HOLD: begin
                if (tmr_zero) begin
                    ctx_d.state    = ST_READY;
                    ctx_d.ref_owed = 1'b1;
                end
            end
            default: begin
                ctx_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q.state     <= ST_IDLE;
            ctx_q.ref_owed  <= 1'b0;
            ctx_q.exit_pend <= 1'b0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    sr_pinmux u_pinmux (
        .state    (ctx_q.state),
        .host_cmd (host_cmd),
        .host_odt (host_odt),
        .cke      (dram_cke),
        .clk_en   (dram_clk_en),
        .odt      (dram_odt),
        .cmd      (dram_cmd),
        .ready    (sr_ready)
    );
endmodule

// File: rtl/sr_sequencer_chk.sv
module sr_sequencer_chk #(
    parameter int T_CKE  = 4,
    parameter int T_CLK  = 3,
    parameter int T_XSRD = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       dram_cke,
    input logic       dram_clk_en,
    input logic       dram_odt,
    input logic [3:0] dram_cmd,
    input logic       sr_ready
);
    logic        cke_prev_q;
    logic [15:0] low_cnt_q;
    logic [15:0] win_q;
    logic        rise;

    assign rise = dram_cke && !cke_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_prev_q <= 1'b1;
            low_cnt_q  <= '0;
            win_q      <= '0;
        end else begin
            cke_prev_q <= dram_cke;
            if (!dram_cke) begin
                if (low_cnt_q != 16'hFFFF) low_cnt_q <= low_cnt_q + 1'b1;
            end else begin
                low_cnt_q <= '0;
            end
            if (rise) begin
                win_q <= 16'(T_XSRD - 1);
            end else if (win_q != '0) begin
                win_q <= win_q - 1'b1;
            end
        end
    end

    a_r3_entry_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cke) |-> (dram_cmd == 4'b0001 && !dram_odt));

    a_r5_min_residency: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (low_cnt_q >= 16'(T_CKE + T_CLK + 1)));

    a_r6_clk_before_cke: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_cke) |-> $past(dram_clk_en));

    a_r6_no_gate_when_cke: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_clk_en |-> !dram_cke);

    a_r7_deselect_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cke && !$fell(dram_cke)) |-> dram_cmd[3]);

    a_r8_exit_window: assert property (@(posedge clk) disable iff (!rst_n)
        (rise || win_q != '0) |-> (dram_cmd == 4'b0111 && !dram_odt && !sr_ready && dram_cke));

    a_r10_ready_pins: assert property (@(posedge clk) disable iff (!rst_n)
        sr_ready |-> (dram_cke && dram_clk_en));
endmodule

bind sr_sequencer sr_sequencer_chk #(
    .T_CKE  (T_CKE),
    .T_CLK  (T_CLK),
    .T_XSRD (T_XSRD)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dram_cke    (dram_cke),
    .dram_clk_en (dram_clk_en),
    .dram_odt    (dram_odt),
    .dram_cmd    (dram_cmd),
    .sr_ready    (sr_ready)
);

// File: tb/sim_sr_sequencer.sv
`timescale 1ns/1ps
module sim_sr_sequencer;
    localparam int T_ODT  = 3;
    localparam int T_RFC  = 6;
    localparam int T_CKE  = 4;
    localparam int T_CLK  = 3;
    localparam int T_XSNR = 8;
    localparam int T_XSRD = 12;

    localparam logic [3:0] NOP   = 4'b0111;
    localparam logic [3:0] DESEL = 4'b1111;
    localparam logic [3:0] REFC  = 4'b0001;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sr_enter_req = 1'b0;
    logic       sr_exit_req = 1'b0;
    logic       banks_idle = 1'b1;
    logic [3:0] host_cmd = NOP;
    logic       host_odt = 1'b0;
    logic       dram_cke, dram_clk_en, dram_odt, sr_ready;
    logic [3:0] dram_cmd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit owed = 1'b0;

    always #2.5 clk = ~clk;

    sr_sequencer #(
        .T_ODT(T_ODT), .T_RFC(T_RFC), .T_CKE(T_CKE),
        .T_CLK(T_CLK), .T_XSNR(T_XSNR), .T_XSRD(T_XSRD)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .sr_enter_req(sr_enter_req),
        .sr_exit_req(sr_exit_req), .banks_idle(banks_idle),
        .host_cmd(host_cmd), .host_odt(host_odt), .dram_cke(dram_cke),
        .dram_clk_en(dram_clk_en), .dram_odt(dram_odt),
        .dram_cmd(dram_cmd), .sr_ready(sr_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // index of the last cycle spent turning termination off
    function automatic int exp_last_odt(input int idle_wait);
        return max2(T_ODT - 1, idle_wait);
    endfunction

    // index of the self-refresh entry cycle
    function automatic int exp_entry(input int idle_wait, input bit ow);
        return exp_last_odt(idle_wait) + 1 + (ow ? T_RFC : 0);
    endfunction

    // index of the last gated-clock cycle
    function automatic int exp_exit_acc(input int s, input int exit_wait);
        return s + max2(T_CKE, exit_wait);
    endfunction

    // passthrough cycles while the host owns the pins (R1, R10, R4 debt clearing)
    task automatic passthrough(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            host_cmd = 4'($urandom_range(0, 15));
            host_odt = 1'($urandom_range(0, 1));
            if (host_cmd == REFC) owed = 1'b0;
            #1;
            chk(dram_cmd == host_cmd, req, "cmd passthrough", dram_cmd, host_cmd);
            chk(dram_odt == host_odt, req, "odt passthrough", dram_odt, host_odt);
            chk(sr_ready && dram_cke && dram_clk_en, req, "ready/cke/clk_en", {sr_ready, dram_cke, dram_clk_en}, 7);
        end
        @(negedge clk);
        host_cmd = NOP;
    endtask

    // full entry/exit sequence with a per-cycle pin model
    task automatic run_sr(input int idle_wait, input int exit_wait,
                          input bit stray_exit, input bit stray_enter);
        int l, s, m, r, rdy;
        logic [3:0] cmd_e;
        bit cke_e, clk_e, odt_e, rdy_e;
        l   = exp_last_odt(idle_wait);
        s   = exp_entry(idle_wait, owed);
        m   = exp_exit_acc(s, exit_wait);
        r   = m + T_CLK + 1;
        rdy = r + T_XSRD;
        @(negedge clk);
        host_cmd = NOP;
        host_odt = 1'b1;
        banks_idle = (idle_wait == 0);
        sr_enter_req = 1'b1;
        @(negedge clk);
        sr_enter_req = 1'b0;
        for (int k = 0; k <= rdy; k++) begin
            banks_idle   = (k >= idle_wait);
            sr_exit_req  = (stray_exit && k == 0) || (k == s + exit_wait);
            sr_enter_req = stray_enter && (k == s + 1);
            #1;
            cke_e = !(k >= s && k < r);
            clk_e = !(k > s && k <= m);
            odt_e = (k >= rdy);
            rdy_e = (k >= rdy);
            if (k <= l)                     cmd_e = NOP;
            else if (owed && k == l + 1)    cmd_e = REFC;
            else if (k < s)                 cmd_e = NOP;
            else if (k == s)                cmd_e = REFC;
            else if (k < r)                 cmd_e = DESEL;
            else if (k < rdy)               cmd_e = NOP;
            else                            cmd_e = host_cmd;
            if (k <= l)
                chk(dram_cmd == cmd_e && !dram_odt, "R2", "odt-off phase cmd/odt", dram_cmd, cmd_e);
            else if (k < s)
                chk(dram_cmd == cmd_e, "R4", "extra refresh cmd", dram_cmd, cmd_e);
            else if (k == s)
                chk(dram_cmd == cmd_e && !dram_odt, "R3", "entry cmd", dram_cmd, cmd_e);
            else if (k < r)
                chk(dram_cmd == cmd_e, "R7", "deselect in self-refresh", dram_cmd, cmd_e);
            else if (k < rdy)
                chk(dram_cmd == cmd_e && !dram_odt, "R8", "exit window NOP", dram_cmd, cmd_e);
            else
                chk(dram_cmd == cmd_e, "R10", "passthrough after exit", dram_cmd, cmd_e);
            chk(dram_cke == cke_e, "R5", $sformatf("cke idx %0d", k), dram_cke, cke_e);
            chk(dram_clk_en == clk_e, "R6", $sformatf("clk_en idx %0d", k), dram_clk_en, clk_e);
            chk(dram_odt == odt_e, "R8", $sformatf("odt idx %0d", k), dram_odt, odt_e);
            chk(sr_ready == rdy_e, (stray_enter ? "R9" : "R8"), $sformatf("ready idx %0d", k), sr_ready, rdy_e);
            if (k < rdy) @(negedge clk);
        end
        sr_exit_req  = 1'b0;
        sr_enter_req = 1'b0;
        banks_idle   = 1'b1;
        owed = 1'b1;
    endtask

    task automatic host_refresh();
        @(negedge clk);
        host_cmd = REFC;
        #1;
        chk(dram_cmd == REFC && dram_cke, "R4", "host refresh passthrough", dram_cmd, REFC);
        owed = 1'b0;
        @(negedge clk);
        host_cmd = NOP;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(sr_ready && dram_cke && dram_clk_en, "R1", "reset outputs", {sr_ready, dram_cke, dram_clk_en}, 7);
        chk(dram_cmd == NOP, "R1", "reset cmd passthrough", dram_cmd, NOP);
        passthrough(6, "R1");

        // R9: stray exit while idle is ignored and not remembered
        @(negedge clk);
        sr_exit_req = 1'b1;
        @(negedge clk);
        sr_exit_req = 1'b0;
        #1;
        chk(sr_ready && dram_cke, "R9", "exit request ignored when idle", {sr_ready, dram_cke}, 3);
        passthrough(2, "R9");

        // directed: fresh entry, exit in the entry cycle itself (R5 pending exit)
        run_sr(0, 0, 1'b0, 1'b0);
        passthrough(3, "R10");
        // directed: owed refresh, exit exactly at the residency boundary, stray requests (R4, R9)
        run_sr(0, T_CKE, 1'b1, 1'b1);
        host_refresh();
        // directed: debt cleared by host, slow banks, late exit
        run_sr(T_ODT + 4, T_CKE + 6, 1'b0, 1'b0);
        // directed: owed refresh with bank wait
        run_sr(T_ODT - 1, T_CKE - 1, 1'b0, 1'b0);

        for (int i = 0; i < 40; i++) begin
            if ($urandom_range(0, 2) == 0) host_refresh();
            passthrough($urandom_range(0, 4), "R10");
            run_sr($urandom_range(0, T_ODT + 5), $urandom_range(0, T_CKE + 6),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule